// File: doc/BRIEF.md
# Power-Up Register Load Sequencer

This block sits in the lead device of a chain of processing devices. It fills the control and coefficient registers from an external read-only memory, with no host processor involved. When a static mode input selects memory-supported loading, the sequencer starts by itself as soon as the active-low reset is released. It reads a fixed window of words for each device in the chain. Each word passes through a fixed four-clock cycle: present the address, wait for the data, pulse the active-low data strobe, then release the strobe and write.

A programming flag stays high for the whole load, so the rest of the system knows that registers are changing. A four-bit device select names the device whose window is being read. A write enable, the word index and the captured data go to the register file. When the load is over, a falling edge on the active-low chip enable starts a complete reload from address zero. A chip-enable edge that arrives during a load is ignored. In host-supported mode the sequencer does nothing.

Top module: `romLoadSeq`

## Requirements
- R1: While `rstN` is low, `progActive` is 0, `dsN` is 1 and `wrEn` is 0.
- R2: With `epromMode` = 1, `progActive` goes high on the first rising clock edge after `rstN` is released.
- R3: Each word takes exactly four clocks: address, wait, strobe, release. `dsN` is low for exactly one clock per word. `wrEn` is high in the clock right after that strobe clock.
- R4: `romAddr` is a flat count starting at 0 at the first word. During the strobe of the k-th word of a load it equals k, which is device × WORDS + word.
- R5: At each write, `wrAddr` is the word index (0 to WORDS-1), `devSel` is the device index (0 to NUM_DEV-1) and `wrData` is the memory byte read at that word's address.
- R6: A load makes exactly WORDS × NUM_DEV writes. `progActive` stays high for exactly 4 × WORDS × NUM_DEV clocks, then returns to 0.
- R7: In idle with `epromMode` = 1, a falling edge on `ceN` starts a full reload from address 0. `progActive` rises on the clock edge that samples `ceN` low.
- R8: A `ceN` falling edge during a load is neither acted on nor stored. The load's length is unchanged, and `progActive` stays 0 afterwards.
- R9: With `epromMode` = 0, no load starts from reset or from `ceN`: `progActive` stays 0, `dsN` stays 1 and `wrEn` stays 0.
- R10: `dsN` is low only while `progActive` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| epromMode | input | 1 | 1 selects memory-supported loading, 0 selects host-supported loading |
| ceN | input | 1 | Active-low chip enable; its falling edge requests a reload |
| romData | input | DATA_W | Byte returned by the external memory |
| romAddr | output | ADDR_W | Address driven to the external memory |
| dsN | output | 1 | Active-low data strobe |
| progActive | output | 1 | High while registers are being loaded |
| devSel | output | SEL_W (4) | Index of the device being loaded |
| wrEn | output | 1 | Register write pulse |
| wrAddr | output | WORD_W | Register index inside the current device |
| wrData | output | DATA_W | Data written to the register |

## Verification
The bench builds the block with WORDS = 6 and NUM_DEV = 3, so one load takes 72 clocks. Every write of every load is compared with an arithmetic model of the memory contents. This small setting covers the word-index wrap, the move to the next device and the end of the final device within each load. It leaves room for a power-on load, a chip-enable pulse during a load, a reload from idle and a host-mode run.

// File: rtl/romLoadSeq_pkg.sv
package romLoadSeq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_STROBE,
    ST_RELEASE
  } seqState_t;

  typedef struct packed {
    logic clear;    // zero counters at the start of a load
    logic latch;    // capture memory data
    logic advance;  // step to next word
  } dpCtrl_t;

endpackage

// File: rtl/romLoadDatapath.sv
module romLoadDatapath
  import romLoadSeq_pkg::*;
#(
  parameter int WORDS   = 72,
  parameter int NUM_DEV = 16,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int SEL_W   = 4,
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [SEL_W-1:0]  devSel,
  output logic [WORD_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              lastWord,
  output logic              lastDev
);

  localparam logic [WORD_W-1:0] WORD_LAST = WORD_W'(WORDS - 1);
  localparam logic [SEL_W-1:0]  DEV_LAST  = SEL_W'(NUM_DEV - 1);

  logic [WORD_W-1:0] wordIdx;
  logic [SEL_W-1:0]  devIdx;
  logic [ADDR_W-1:0] addrCnt;
  logic [DATA_W-1:0] dataReg;

  assign lastWord = (wordIdx == WORD_LAST);
  assign lastDev  = (devIdx == DEV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx <= '0;
      devIdx  <= '0;
      addrCnt <= '0;
    end else if (ctrl.clear) begin
      wordIdx <= '0;
      devIdx  <= '0;
      addrCnt <= '0;
    end else if (ctrl.advance) begin
      addrCnt <= addrCnt + 1'b1;
      if (lastWord) begin
        wordIdx <= '0;
        devIdx  <= devIdx + 1'b1;
      end else begin
        wordIdx <= wordIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           dataReg <= '0;
    else if (ctrl.latch) dataReg <= romData;
  end

  assign romAddr = addrCnt;
  assign devSel  = devIdx;
  assign wrAddr  = wordIdx;
  assign wrData  = dataReg;

endmodule

// File: rtl/romLoadControl.sv
module romLoadControl
  import romLoadSeq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    epromMode,
  input  logic    ceN,
  input  logic    lastWord,
  input  logic    lastDev,
  output dpCtrl_t ctrl,
  output logic    progActive,
  output logic    dsN,
  output logic    wrEn
);

  seqState_t state, stateNext;
  logic bootPend;
  logic ceSeen;
  logic ceFall;
  logic startLoad;

  assign ceFall    = ceSeen && !ceN;
  assign startLoad = (state == ST_IDLE) && epromMode && (bootPend || ceFall);

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (startLoad) begin
          ctrl.clear = 1'b1;
          stateNext  = ST_ADDR;
        end
      end
      ST_ADDR:   stateNext = ST_WAIT;
      ST_WAIT: begin
        ctrl.latch = 1'b1;
        stateNext  = ST_STROBE;
      end
      ST_STROBE: stateNext = ST_RELEASE;
      ST_RELEASE: begin
        ctrl.advance = 1'b1;
        stateNext    = (lastWord && lastDev) ? ST_IDLE : ST_ADDR;
      end
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bootPend <= 1'b1;
      ceSeen   <= 1'b1;
    end else begin
      state  <= stateNext;
      ceSeen <= ceN;
      if (startLoad) bootPend <= 1'b0;
    end
  end

  assign progActive = (state != ST_IDLE);
  assign dsN        = (state != ST_STROBE);
  assign wrEn       = (state == ST_RELEASE);

endmodule

// File: rtl/romLoadSeq.sv
module romLoadSeq
  import romLoadSeq_pkg::*;
#(
  parameter int WORDS   = 72,
  parameter int NUM_DEV = 16,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int SEL_W   = 4,
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              epromMode,
  input  logic              ceN,
  input  logic [DATA_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              dsN,
  output logic              progActive,
  output logic [SEL_W-1:0]  devSel,
  output logic              wrEn,
  output logic [WORD_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  dpCtrl_t ctrl;
  logic    lastWord;
  logic    lastDev;

  romLoadControl u_control (
    .clk        (clk),
    .rstN       (rstN),
    .epromMode  (epromMode),
    .ceN        (ceN),
    .lastWord   (lastWord),
    .lastDev    (lastDev),
    .ctrl       (ctrl),
    .progActive (progActive),
    .dsN        (dsN),
    .wrEn       (wrEn)
  );

  romLoadDatapath #(
    .WORDS   (WORDS),
    .NUM_DEV (NUM_DEV),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SEL_W   (SEL_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .romData  (romData),
    .romAddr  (romAddr),
    .devSel   (devSel),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .lastWord (lastWord),
    .lastDev  (lastDev)
  );

endmodule

// File: rtl/romLoadSeq_checker.sv
module romLoadSeq_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              epromMode,
  input logic              dsN,
  input logic              progActive,
  input logic              wrEn,
  input logic [ADDR_W-1:0] romAddr
);

  p_strobe_in_prog_r10: assert property (@(posedge clk) disable iff (!rstN)
    !dsN |-> progActive);

  p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    !dsN |=> dsN);

  p_write_after_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(!dsN));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !dsN |-> $stable(romAddr));

  p_write_in_prog_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> progActive);

  p_host_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!epromMode && !progActive) |=> !progActive);

endmodule

bind romLoadSeq romLoadSeq_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .epromMode  (epromMode),
  .dsN        (dsN),
  .progActive (progActive),
  .wrEn       (wrEn),
  .romAddr    (romAddr)
);

// File: tb/romLoadSeq_bench.sv
module romLoadSeq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS   = 6;
  localparam int NUM_DEV = 3;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int SEL_W   = 4;
  localparam int WORD_W  = $clog2(WORDS);
  localparam int TOTAL   = WORDS * NUM_DEV;

  logic              clk = 1'b0;
  logic              rstN;
  logic              epromMode;
  logic              ceN;
  logic [DATA_W-1:0] romData;
  logic [ADDR_W-1:0] romAddr;
  logic              dsN;
  logic              progActive;
  logic [SEL_W-1:0]  devSel;
  logic              wrEn;
  logic [WORD_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] romModel(input int a);
    return DATA_W'((a * 37 + 11) & 8'hFF);
  endfunction

  assign romData = romModel(int'(romAddr));

  romLoadSeq #(
    .WORDS(WORDS), .NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_romLoadSeq (
    .clk(clk), .rstN(rstN), .epromMode(epromMode), .ceN(ceN),
    .romData(romData), .romAddr(romAddr), .dsN(dsN),
    .progActive(progActive), .devSel(devSel), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Follows one load from the negedge after its start; pulses ceN at cycle pulseAt.
  task automatic runLoad(input string req, input int pulseAt);
    int writes = 0;
    int strobes = 0;
    int progCyc = 0;
    bit prevDs = 1'b1;
    for (int cyc = 0; cyc < 4 * TOTAL + 20; cyc++) begin
      @(negedge clk);
      if (cyc == 0) check(progActive == 1'b1, req, "load start", progActive, 1);
      if (!progActive) break;
      progCyc++;
      if (!dsN) begin
        check(prevDs == 1'b1, "R3", "strobe one clock", 0, 1);
        check(int'(romAddr) == strobes, "R4", "address at strobe", romAddr, strobes);
        strobes++;
      end
      if (wrEn) begin
        check(prevDs == 1'b0, "R3", "write after strobe", prevDs, 0);
        check(int'(wrAddr) == writes % WORDS, "R5", "word index", wrAddr, writes % WORDS);
        check(int'(devSel) == writes / WORDS, "R5", "device select", devSel, writes / WORDS);
        check(wrData == romModel(writes), "R5", "write data", wrData, romModel(writes));
        writes++;
      end
      prevDs = dsN;
      ceN = (cyc == pulseAt) ? 1'b0 : 1'b1;
    end
    check(writes == TOTAL, "R6", "write count", writes, TOTAL);
    check(strobes == TOTAL, "R3", "strobe count", strobes, TOTAL);
    check(progCyc == 4 * TOTAL, "R6", "busy clocks", progCyc, 4 * TOTAL);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0;
    epromMode = 1'b1;
    ceN = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(progActive == 1'b0, "R1", "prog in reset", progActive, 0);
    check(dsN == 1'b1, "R1", "strobe in reset", dsN, 1);
    check(wrEn == 1'b0, "R1", "write in reset", wrEn, 0);
    rstN = 1'b1;

    // R2 power-on load, with an R8 chip-enable pulse in the middle
    runLoad("R2", 10);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(progActive == 1'b0, "R8", "no queued reload", progActive, 0);
    end

    // R7 reload from idle
    ceN = 1'b0;
    runLoad("R7", -1);
    repeat (3) @(negedge clk);
    check(progActive == 1'b0, "R6", "idle after reload", progActive, 0);

    // R9 host mode
    epromMode = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      ceN = (i % 5 == 2) ? 1'b0 : 1'b1;
      check(progActive == 1'b0, "R9", "host prog", progActive, 0);
      check(dsN == 1'b1, "R9", "host strobe", dsN, 1);
      check(wrEn == 1'b0, "R9", "host write", wrEn, 0);
    end

    summary();
    $finish;
  end

endmodule